// File: doc/BRIEF.md
# Memory BIST Write-Pattern Generator

This block supplies the write data for a memory self-test engine. Each pattern is 144 bits wide: an early beat and a late beat, each with 64 data bits and 8 check bits. The data comes from five 32-bit words connected in a ring. On every advance, each word moves one place along the ring and is rotated left by one bit as it moves. The check bytes of both beats come from the low half of the head word, and the four other words fill the data lanes.

There are two fill modes. In circular-shift mode, a start pulse loads the seed into the head word and clears the other four words. A single set bit then walks through every lane as patterns are requested. In LFSR mode, the word entering the head is a CRC-32 step of the current head rather than the rotated tail word. After start, the block performs five loads on its own before it marks the first pattern valid, so every lane already holds generated data. An invert control complements the whole output without changing the stored words.

Top module: `mbist_pat_gen`

## Requirements
- R1: While reset is asserted and after it is released, `valid_o` is 0 until a start pulse is seen. A request with `valid_o` low changes nothing.
- R2: In circular-shift mode, a start pulse loads the head word with `seed_i` and clears the other four words. `valid_o` is 1 in the cycle after the start edge.
- R3: In circular-shift mode, a request with `valid_o` high moves each word one place along the ring at the next edge, in the order head, w1, w2, w3, w4, head. Each moved word is rotated left by one bit. With seed 1, after five requests the early check byte reads 0x20.
- R4: With `valid_o` high and neither start nor request, the pattern and `valid_o` hold their values.
- R5: Output lanes: bits [31:0] are w4, [63:32] are w3, [71:64] are head[7:0], [103:72] are w2, [135:104] are w1, and [143:136] are head[15:8].
- R6: In LFSR mode, a load writes the CRC-32 step of the current head into the head word, while w1 to w4 take their rotated ring inputs. After start, the head holds the seed, so the first CRC input is the seed.
- R7: In LFSR mode, a start pulse loads the seed into the head word and clears w1 to w4. It then triggers five automatic loads on the five following edges, and `valid_o` rises with the fifth. Requests are ignored while these loads run. Afterwards each request performs one load.
- R8: The CRC-32 step uses polynomial 0x04C11DB7. It shifts the 32-bit word left 32 times, and each time the bit shifted out is 1 the polynomial is XORed into the word.
- R9: With `invert_i` high, all 144 output bits are complemented, and this takes effect in the same cycle. The stored words are unchanged, so clearing `invert_i` restores the original pattern.
- R10: `mode_i` is sampled only at start. Code 3 selects LFSR mode, and every other code selects circular-shift mode. A start pulse takes priority over a request in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Fill mode code, sampled at start |
| invert_i | input | 1 | Complement the output pattern |
| seed_i | input | 32 | Seed word for the head |
| start_i | input | 1 | Start pulse |
| req_i | input | 1 | Request the next pattern |
| pat_o | output | 144 | Pattern output |
| valid_o | output | 1 | Pattern valid |

## Verification
The bench builds the block with its default 32-bit word and the default CRC-32 polynomial, so the lane boundaries the bench checks are the real 144-bit ones. A behavioural model of the ring is compared on every clock. It runs the seed-1 walk through every lane, a full LFSR fill from an arbitrary seed, and a restart in the middle of a fill. With these defaults the bench also reaches a start and a request in the same cycle, a change of mode code while a run is active, and toggling invert on a held pattern.

// File: rtl/mbist_pat_pkg.sv
package mbist_pat_pkg;
  localparam logic [1:0] MODE_CIRC = 2'd2;
  localparam logic [1:0] MODE_LFSR = 2'd3;
  localparam int unsigned RING_LEN = 5;
  localparam int unsigned CB_W     = 8;
endpackage

// File: rtl/mbist_crc_step.sv
module mbist_crc_step #(
  parameter int unsigned       W    = 32,
  parameter logic [W-1:0]      POLY = 32'h04C11DB7
) (
  input  logic [W-1:0] in_i,
  output logic [W-1:0] out_o
);
  // W serial shifts with no data input, unrolled into one cycle
  always_comb begin
    logic [W-1:0] s;
    s = in_i;
    for (int k = 0; k < W; k++) begin
      if (s[W-1]) s = {s[W-2:0], 1'b0} ^ POLY;
      else        s = {s[W-2:0], 1'b0};
    end
    out_o = s;
  end
endmodule

// File: rtl/mbist_pat_ring.sv
module mbist_pat_ring #(
  parameter int unsigned W = 32,
  parameter int unsigned N = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_i,
  input  logic [W-1:0]      seed_i,
  input  logic              load_i,
  input  logic [W-1:0]      feed_i,
  output logic [N-1:0][W-1:0] ring_o
);
  logic [N-1:0][W-1:0] ring_q;

  for (genvar i = 0; i < N; i++) begin : g_word
    logic [W-1:0] init_val, hop_val;
    if (i == 0) begin : g_head
      assign init_val = seed_i;
      assign hop_val  = feed_i;
    end else begin : g_body
      assign init_val = '0;
      assign hop_val  = {ring_q[i-1][W-2:0], ring_q[i-1][W-1]};
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     ring_q[i] <= '0;
      else if (init_i) ring_q[i] <= init_val;
      else if (load_i) ring_q[i] <= hop_val;
    end
  end

  assign ring_o = ring_q;
endmodule

// File: rtl/mbist_pat_map.sv
module mbist_pat_map #(
  parameter int unsigned W    = 32,
  parameter int unsigned N    = 5,
  parameter int unsigned CB_W = 8,
  localparam int unsigned PAT_W = 4 * W + 2 * CB_W
) (
  input  logic [N-1:0][W-1:0] ring_i,
  input  logic                invert_i,
  output logic [PAT_W-1:0]    pat_o
);
  logic [PAT_W-1:0] raw;
  // late cb | w1 | w2 | early cb | w3 | w4
  assign raw = {ring_i[0][2*CB_W-1:CB_W], ring_i[1], ring_i[2],
                ring_i[0][CB_W-1:0], ring_i[3], ring_i[4]};
  assign pat_o = raw ^ {PAT_W{invert_i}};
endmodule

// File: rtl/mbist_pat_gen.sv
module mbist_pat_gen
  import mbist_pat_pkg::*;
#(
  parameter int unsigned  WORD_W = 32,
  parameter logic [WORD_W-1:0] CRC_POLY = 32'h04C11DB7,
  localparam int unsigned PAT_W  = 4 * WORD_W + 2 * CB_W,
  localparam int unsigned FILL_W = $clog2(RING_LEN + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic              invert_i,
  input  logic [WORD_W-1:0] seed_i,
  input  logic              start_i,
  input  logic              req_i,
  output logic [PAT_W-1:0]  pat_o,
  output logic              valid_o
);
  logic [RING_LEN-1:0][WORD_W-1:0] ring_w;
  logic [WORD_W-1:0] crc_w, feed_w;
  logic [FILL_W-1:0] fill_q;
  logic lfsr_q, valid_q, load_w, filling_w;

  assign filling_w = (fill_q != '0);
  assign load_w    = !start_i && (filling_w || (req_i && valid_q));
  assign feed_w    = lfsr_q ? crc_w
                            : {ring_w[RING_LEN-1][WORD_W-2:0], ring_w[RING_LEN-1][WORD_W-1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lfsr_q  <= 1'b0;
      valid_q <= 1'b0;
      fill_q  <= '0;
    end else if (start_i) begin
      lfsr_q  <= (mode_i == MODE_LFSR);
      valid_q <= (mode_i != MODE_LFSR);
      fill_q  <= (mode_i == MODE_LFSR) ? FILL_W'(RING_LEN) : '0;
    end else if (filling_w) begin
      fill_q  <= fill_q - 1'b1;
      valid_q <= (fill_q == FILL_W'(1));
    end
  end

  mbist_crc_step #(.W(WORD_W), .POLY(CRC_POLY)) crc_i (
    .in_i (ring_w[0]),
    .out_o(crc_w)
  );

  mbist_pat_ring #(.W(WORD_W), .N(RING_LEN)) ring_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .init_i(start_i),
    .seed_i(seed_i),
    .load_i(load_w),
    .feed_i(feed_w),
    .ring_o(ring_w)
  );

  mbist_pat_map #(.W(WORD_W), .N(RING_LEN), .CB_W(CB_W)) map_i (
    .ring_i  (ring_w),
    .invert_i(invert_i),
    .pat_o   (pat_o)
  );

  assign valid_o = valid_q;
endmodule

// File: rtl/mbist_pat_gen_chk.sv
module mbist_pat_gen_chk
  import mbist_pat_pkg::*;
#(
  parameter int unsigned W = 32,
  parameter int unsigned N = 5,
  parameter int unsigned PAT_W = 144
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [1:0]          mode_i,
  input logic                invert_i,
  input logic                start_i,
  input logic                req_i,
  input logic [PAT_W-1:0]    pat_o,
  input logic                valid_o,
  input logic [N-1:0][W-1:0] ring_i
);
  logic [PAT_W-1:0] raw;
  assign raw = pat_o ^ {PAT_W{invert_i}};

  function automatic logic [W-1:0] rotl(input logic [W-1:0] x);
    return {x[W-2:0], x[W-1]};
  endfunction

  AST_CIRC_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && mode_i != MODE_LFSR |=> valid_o && ring_i[1] == '0); // R2
  AST_LFSR_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && mode_i == MODE_LFSR |=> !valid_o); // R7
  AST_VALID_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !start_i |=> valid_o); // R4
  AST_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !req_i && !start_i |=> raw == $past(raw)); // R4
  AST_HOP_ROT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && req_i && !start_i |=> ring_i[2] == rotl($past(ring_i[1]))); // R3
  AST_TAIL_LANE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pat_o[W-1:0] == (ring_i[N-1] ^ {W{invert_i}})); // R9
endmodule

bind mbist_pat_gen mbist_pat_gen_chk #(.W(WORD_W), .N(mbist_pat_pkg::RING_LEN), .PAT_W(PAT_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .invert_i(invert_i),
  .start_i(start_i), .req_i(req_i), .pat_o(pat_o), .valid_o(valid_o), .ring_i(ring_w)
);

// File: tb/mbist_pat_gen_tb.sv
module mbist_pat_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PAT_W = 144;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode = 2'd2;
  logic invert = 1'b0, start = 1'b0, req = 1'b0;
  logic [31:0] seed = '0;
  logic [PAT_W-1:0] pat;
  logic valid;

  int checks = 0, errors = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbist_pat_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .invert_i(invert),
    .seed_i(seed), .start_i(start), .req_i(req), .pat_o(pat), .valid_o(valid)
  );

  // behavioural model
  logic [31:0] m [5];
  logic m_valid = 1'b0, m_lfsr = 1'b0;
  int m_fill = 0;

  function automatic logic [31:0] rotl(input logic [31:0] x);
    return {x[30:0], x[31]};
  endfunction

  function automatic logic [31:0] crc(input logic [31:0] x);
    logic [31:0] s = x;
    for (int k = 0; k < 32; k++) begin
      logic top = s[31];
      s = s << 1;
      if (top) s = s ^ 32'h04C11DB7;
    end
    return s;
  endfunction

  function automatic logic [PAT_W-1:0] exp_pat();
    logic [PAT_W-1:0] p = {m[0][15:8], m[1], m[2], m[0][7:0], m[3], m[4]};
    return invert ? ~p : p;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 5; i++) m[i] = '0;
      m_valid = 1'b0; m_lfsr = 1'b0; m_fill = 0;
    end else if (start) begin
      m_lfsr = (mode == 2'd3);
      m[0] = seed;
      for (int i = 1; i < 5; i++) m[i] = '0;
      m_fill = m_lfsr ? 5 : 0;
      m_valid = !m_lfsr;
    end else if (m_fill > 0 || (req && m_valid)) begin
      logic [31:0] o [5];
      for (int i = 0; i < 5; i++) o[i] = m[i];
      m[0] = m_lfsr ? crc(o[0]) : rotl(o[4]);
      for (int i = 1; i < 5; i++) m[i] = rotl(o[i-1]);
      if (m_fill > 0) begin
        m_fill--;
        if (m_fill == 0) m_valid = 1'b1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [PAT_W-1:0] act, input logic [PAT_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk(valid === m_valid, "R4 valid track", PAT_W'(valid), PAT_W'(m_valid));
    if (m_valid) chk(pat === exp_pat(), "R5 pattern track", pat, exp_pat());
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 100000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  initial begin
    logic [31:0] c1, c5, c6;
    logic [PAT_W-1:0] held;
    tick(2);
    chk(valid === 1'b0, "R1 valid in reset", PAT_W'(valid), '0);
    rst_n = 1'b1;
    req = 1'b1; tick(3); req = 1'b0;
    chk(valid === 1'b0, "R1 req before start", PAT_W'(valid), '0);

    // circular walk, seed 1
    mode = 2'd2; seed = 32'h1; start = 1'b1; tick(); start = 1'b0;
    chk(valid === 1'b1, "R2 valid after start", PAT_W'(valid), PAT_W'(1));
    chk(pat === PAT_W'(72'h01 << 64), "R2 head seed others clear", pat, PAT_W'(72'h01 << 64));
    mode = 2'd3; // latched at start: must stay circular (R10)
    req = 1'b1; tick(); req = 1'b0;
    chk(pat[135:104] === 32'h2, "R5 w1 lane", PAT_W'(pat[135:104]), PAT_W'(2));
    tick(2);
    chk(pat[135:104] === 32'h2, "R4 hold w/o req", PAT_W'(pat[135:104]), PAT_W'(2));
    req = 1'b1; tick(); req = 1'b0;
    chk(pat[103:72] === 32'h4, "R5 w2 lane", PAT_W'(pat[103:72]), PAT_W'(4));
    req = 1'b1; tick(); req = 1'b0;
    chk(pat[63:32] === 32'h8, "R5 w3 lane", PAT_W'(pat[63:32]), PAT_W'(8));
    req = 1'b1; tick(); req = 1'b0;
    chk(pat[31:0] === 32'h10, "R5 w4 lane", PAT_W'(pat[31:0]), PAT_W'(16));
    req = 1'b1; tick(); req = 1'b0;
    chk(pat[71:64] === 8'h20, "R3 early cb after wrap", PAT_W'(pat[71:64]), PAT_W'(8'h20));
    chk(pat[63:0] === 64'h0, "R10 mode latched circular", PAT_W'(pat[63:0]), '0);

    // invert
    held = pat;
    invert = 1'b1; #1;
    chk(pat === ~held, "R9 invert all bits", pat, ~held);
    invert = 1'b0; #1;
    chk(pat === held, "R9 contents kept", pat, held);

    // start and req together, code 0 is circular
    mode = 2'd0; seed = 32'hDEAD_BEEF; start = 1'b1; req = 1'b1; tick();
    start = 1'b0; req = 1'b0;
    chk(valid === 1'b1 && pat[135:104] === 32'h0 && pat[71:64] === 8'hEF,
        "R10 start wins, code 0 circular", pat, PAT_W'(8'hEF) << 64);

    // LFSR fill
    seed = 32'hACE1_1357; mode = 2'd3; start = 1'b1; tick(); start = 1'b0;
    chk(valid === 1'b0, "R7 not valid at start", PAT_W'(valid), '0);
    req = 1'b1; tick(2); req = 1'b0; // ignored during fill
    c1 = crc(seed);
    c5 = crc(crc(crc(crc(c1))));
    tick(2);
    chk(valid === 1'b0, "R7 not valid after 4 loads", PAT_W'(valid), '0);
    tick();
    chk(valid === 1'b1, "R7 valid after 5 loads", PAT_W'(valid), PAT_W'(1));
    chk({pat[143:136], pat[71:64]} === c5[15:0], "R8 head crc^5", PAT_W'({pat[143:136], pat[71:64]}), PAT_W'(c5[15:0]));
    chk(pat[31:0] === rotl(rotl(rotl(rotl(c1)))), "R7 tail holds generated", PAT_W'(pat[31:0]), PAT_W'(rotl(rotl(rotl(rotl(c1))))));
    c6 = crc(c5);
    req = 1'b1; tick(); req = 1'b0;
    chk({pat[143:136], pat[71:64]} === c6[15:0] && pat[135:104] === rotl(c5),
        "R6 one load per req", pat, {PAT_W'(c6[15:0])});

    // restart mid-fill and random traffic
    start = 1'b1; tick(); start = 1'b0; tick(2);
    seed = 32'h0F0F_00F1; start = 1'b1; tick(); start = 1'b0;
    for (int i = 0; i < 60; i++) begin
      req = (i % 3 != 0); invert = (i % 7 == 0); tick();
    end
    req = 1'b0; invert = 1'b0;
    mode = 2'd1; seed = 32'h8000_0003; start = 1'b1; tick(); start = 1'b0;
    for (int i = 0; i < 40; i++) begin req = (i % 2 == 0); tick(); end
    req = 1'b0; tick(2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule